// File: doc/BRIEF.md
# Register-Copy Execute Sequencer

This block is the hardwired execute-step decoder for the register-to-register copy operation of a small 12-bit processor. It looks at the two machine-state bits, the three-bit execute step count and the instruction word. When all four of these match the copy operation, it drives two active-low strobes during the first execute step. One is an output-enable for the source register, which places that register's value on the shared data bus. The other is a write strobe for the target register.

The target register captures the bus on the next falling clock edge. On that same falling edge the block registers an active-high end-of-sequence pulse, so the step counter and fetch logic know the operation took one clock period. The register file, the bus, the step counter and the decoders for other instruction classes sit outside this block. Several decoders like this one, one per instruction class, share the same state and step inputs.

Top module: `regcopy_seq`

## Requirements
- R1: Every strobe is high (inactive) unless the machine state input equals 2'b11, the execute state.
- R2: Every strobe is high unless instruction bits 11:9 equal 3'b100.
- R3: Every strobe is high unless instruction bits 5:3 equal 3'b000.
- R4: Every strobe is high unless the step count equals 3'b000, the first execute step.
- R5: When any of the conditions in R1 to R4 fails, `oe_n` and `wr_n` both read 8'hFF.
- R6: When all conditions hold, exactly one `oe_n` bit is low: bit k, where k is instruction bits 2:0 (the source register).
- R7: When all conditions hold, exactly one `wr_n` bit is low: bit k, where k is instruction bits 8:6 (the target register). It is asserted in the same cycle as the R6 strobe.
- R8: When the source and target fields are equal, the matching `oe_n` bit and `wr_n` bit are both low, with no special handling.
- R9: `eos` is updated on each falling clock edge. Its new value is 1 exactly when the strobes were active just before that edge, so one enabled cycle gives a one-cycle-wide pulse.
- R10: While `rst` is high at a falling edge, `eos` becomes 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `eos` is updated on its falling edge |
| rst | input | 1 | Synchronous active-high reset for `eos` |
| mstate | input | 2 | Machine state bits; 2'b11 is execute |
| step | input | 3 | Execute step count; 3'b000 is the first step |
| instr | input | 12 | Current instruction word |
| oe_n | output | 8 | Active-low output-enable strobes, one per register |
| wr_n | output | 8 | Active-low write strobes, one per register |
| eos | output | 1 | Active-high end-of-sequence pulse, registered on the falling edge |

## Verification
The assertions assume that the state, step and instruction inputs change only near the rising clock edge and are settled by the falling edge. This matches how the surrounding machine would drive them. The bench follows that rule: it applies each new input combination shortly after a rising edge, reads the strobes before the falling edge, and reads `eos` just after it. The stimulus covers every combination of state, class, sub-opcode and step, with varied register fields. It then covers all 64 source and target pairs with the enabling condition, and finally holds the enabling inputs while reset is high.

// File: rtl/regcopy_seq.sv
module regcopy_seq #(
  parameter int          REG_BITS   = 3,
  parameter logic [1:0]  EXEC_STATE = 2'b11,
  parameter logic [2:0]  CLASS_CODE = 3'b100,
  parameter logic [2:0]  SUBOP_CODE = 3'b000,
  parameter logic [2:0]  FIRST_STEP = 3'b000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  mstate,
  input  logic [2:0]                  step,
  input  logic [11:0]                 instr,
  output logic [(1<<REG_BITS)-1:0]    oe_n,
  output logic [(1<<REG_BITS)-1:0]    wr_n,
  output logic                        eos
);
  localparam int NREG    = 1 << REG_BITS;
  localparam int SRC_LSB = 0;
  localparam int SUB_LSB = 3;
  localparam int DST_LSB = 6;
  localparam int CLS_LSB = 9;

  logic [REG_BITS-1:0] src_sel, dst_sel;
  logic                in_exec, cls_hit, sub_hit, step_hit, fire;

  assign in_exec  = (mstate == EXEC_STATE);
  assign cls_hit  = (instr[CLS_LSB +: 3] == CLASS_CODE);
  assign sub_hit  = (instr[SUB_LSB +: 3] == SUBOP_CODE);
  assign step_hit = (step == FIRST_STEP);
  assign fire     = in_exec & cls_hit & sub_hit & step_hit;

  assign src_sel = instr[SRC_LSB +: REG_BITS];
  assign dst_sel = instr[DST_LSB +: REG_BITS];

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign oe_n[k] = ~(fire & (src_sel == REG_BITS'(k)));
    assign wr_n[k] = ~(fire & (dst_sel == REG_BITS'(k)));
  end

  always_ff @(negedge clk) begin
    if (rst) eos <= 1'b0;
    else     eos <= fire;
  end

  p_state_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (mstate != EXEC_STATE) |-> (&oe_n && &wr_n));
  p_class_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (instr[11:9] != CLASS_CODE) |-> (&oe_n && &wr_n));
  p_subop_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (instr[5:3] != SUBOP_CODE) |-> (&oe_n && &wr_n));
  p_step_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (step != FIRST_STEP) |-> (&oe_n && &wr_n));
  p_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
    ($countones(~oe_n) == 0) |-> ($countones(~wr_n) == 0));
  p_src_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~oe_n));
  p_dst_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones(~oe_n) == 1) |-> ($countones(~wr_n) == 1 && !wr_n[instr[8:6]]));
  p_same_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (!oe_n[instr[2:0]] && instr[2:0] == instr[8:6]) |-> !wr_n[instr[2:0]]);
  p_eos_set_r9: assert property (@(negedge clk) disable iff (rst)
    (!(&oe_n)) |=> eos);
  p_eos_clr_r9: assert property (@(negedge clk) disable iff (rst)
    (&oe_n) |=> !eos);
endmodule

// File: tb/test_regcopy_seq.sv
module test_regcopy_seq;
  localparam int PERIOD = 10;
  localparam int LIMIT  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mstate = '0;
  logic [2:0]  step = '0;
  logic [11:0] instr = '0;
  logic [7:0]  oe_n, wr_n;
  logic        eos;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  regcopy_seq i_regcopy_seq (
    .clk(clk), .rst(rst), .mstate(mstate), .step(step),
    .instr(instr), .oe_n(oe_n), .wr_n(wr_n), .eos(eos)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply(input int s, input int c, input int o, input int e,
                       input int d, input int r, input string tag);
    bit fire;
    logic [7:0] exp_oe, exp_wr;
    @(posedge clk);
    #1;
    mstate = 2'(s);
    step   = 3'(e);
    instr  = {3'(c), 3'(d), 3'(o), 3'(r)};
    fire   = (s == 3) && (c == 4) && (o == 0) && (e == 0);
    exp_oe = 8'hFF;
    exp_wr = 8'hFF;
    if (fire) begin
      exp_oe[r] = 1'b0;
      exp_wr[d] = 1'b0;
    end
    #3;
    check({tag, " oe_n"}, oe_n, exp_oe);
    check({tag, " wr_n"}, wr_n, exp_wr);
    @(negedge clk);
    #1;
    check("R9 eos", {7'b0, eos}, {7'b0, fire});
  endtask

  initial begin
    #(PERIOD * LIMIT);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mstate = 2'b11; step = 3'b000; instr = 12'b100_010_000_101;
    @(negedge clk); #1;
    check("R10 eos in reset", {7'b0, eos}, 8'h00);
    @(negedge clk); #1;
    check("R10 eos held in reset", {7'b0, eos}, 8'h00);
    @(posedge clk); #1;
    rst = 1'b0;

    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 8; c++)
        for (int o = 0; o < 8; o++)
          for (int e = 0; e < 8; e++) begin
            string tag;
            if (s != 3) tag = "R1/R5";
            else if (c != 4) tag = "R2/R5";
            else if (o != 0) tag = "R3/R5";
            else if (e != 0) tag = "R4/R5";
            else tag = "R6/R7";
            apply(s, c, o, e, (c * 3 + e) % 8, (o * 5 + s) % 8, tag);
          end

    for (int d = 0; d < 8; d++)
      for (int r = 0; r < 8; r++)
        apply(3, 4, 0, 0, d, r, (d == r) ? "R8" : "R6/R7");

    apply(3, 4, 0, 0, 2, 6, "R6/R7");
    apply(3, 4, 0, 1, 2, 6, "R4 step advance");

    @(posedge clk); #1;
    mstate = 2'b11; step = 3'b000; instr = 12'b100_001_000_011;
    rst = 1'b1;
    @(negedge clk); #1;
    check("R10 reset over fire", {7'b0, eos}, 8'h00);
    check("R6 strobes in reset", oe_n, 8'hF7);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk); #1;
    check("R9 eos after reset", {7'b0, eos}, 8'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule